// File: doc/BRIEF.md
# Word-Assembling DMA Controller

This block is a single-channel direct memory access engine that connects a byte-wide peripheral stream to a word-addressed main memory. Before a transfer the CPU loads a word address and a word count through a small register-load port, then writes a control word that carries a start bit and a direction bit.

When moving data into memory, the controller accepts characters from the device and packs them into a word buffer. Each full word is written to memory at the current address. The address then advances by one word and the count drops by one. When moving data out of memory, the controller fetches one word at a time and sends it to the device one character at a time. The transfer stops when the count reaches zero, and a completion interrupt is raised. If the device flags a verification error on a character it delivers, the transfer is halted and an error interrupt is raised. A CPU control write clears both interrupts.

Top module: `wdma_ctrl`

## Requirements
- R1: After reset `busy`, `mem_req`, `in_ready`, `out_valid`, `irq_done` and `irq_err` are all low.
- R2: A write with `cfg_we` high loads the word address when `cfg_sel`=0, loads the word count when `cfg_sel`=1, and is a control write when `cfg_sel`=2. Control bits: bit 0 starts a transfer, bit 1 selects direction (0 = device to memory, 1 = memory to device), bit 2 clears both interrupts.
- R3: In the device-to-memory direction, characters are packed little-endian. The first accepted character of a word lands in bits [7:0] of the written word, the second in [15:8], and so on.
- R4: A memory write is requested only after a full word of characters has been accepted. While that write is pending, `in_ready` is low.
- R5: Once `mem_req` is high it stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until the cycle in which `mem_gnt` is sampled high.
- R6: The first access of a transfer uses the loaded address. Each granted access advances the address by one.
- R7: Exactly as many words as the loaded count are moved. Then `busy` falls and `irq_done` is set.
- R8: Starting with a count of zero performs no memory access. `irq_done` is high one cycle after the start write.
- R9: A character accepted with `in_err` high is not stored. It halts the transfer (`busy` low), sets `irq_err`, and no further memory write is made.
- R10: In the memory-to-device direction, each fetched word is sent on `out_data` least significant character first. A character is sent on every cycle where `out_valid` and `out_ready` are both high.
- R11: A control write with bit 2 set clears `irq_done` and `irq_err` on the next cycle.
- R12: While `busy` is high, writes to the address, count or start bit have no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | CPU register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | RW (16) | CPU write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write when high |
| mem_addr | output | AW (16) | Word address |
| mem_wdata | output | DW (32) | Write data |
| mem_gnt | input | 1 | Grant; completes the access in the cycle it is sampled |
| mem_rdata | input | DW (32) | Read data, valid while `mem_gnt` is high |
| in_valid | input | 1 | Device offers a character |
| in_data | input | BW (8) | Incoming character |
| in_err | input | 1 | Verification error on the offered character |
| in_ready | output | 1 | Controller accepts a character |
| out_valid | output | 1 | Outgoing character valid |
| out_data | output | BW (8) | Outgoing character |
| out_ready | input | 1 | Device takes the outgoing character |
| irq_done | output | 1 | Completion interrupt |
| irq_err | output | 1 | Verification error interrupt |
| busy | output | 1 | Transfer in progress |

## Verification
Every result appears one clock edge after its cause. `irq_done` follows the start write or the last grant or last character. `irq_err` and the fall of `busy` follow the bad character. A write request follows the fourth accepted character, and the address step follows the grant. The bench drives every input on the falling edge. It samples outputs on the next falling edge, which is half a cycle after the edge that consumes the stimulus. Because handshake outputs come straight from state registers, the device, memory and sink models decide each handshake from values that are already stable at that falling edge.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_STORE,
    ST_FETCH,
    ST_DRAIN
  } wdma_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int CTL_START = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_CLR   = 2;
endpackage

// File: rtl/wdma_word_buf.sv
module wdma_word_buf #(
  parameter int BW    = 8,
  parameter int BYTES = 4,
  localparam int DW   = BW * BYTES,
  localparam int LW   = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_lane,
  input  logic          load_word,
  input  logic [DW-1:0] word_in,
  input  logic          put_byte,
  input  logic [BW-1:0] byte_in,
  input  logic          adv,
  output logic          lane_last,
  output logic [DW-1:0] word_out,
  output logic [BW-1:0] byte_out
);
  logic [DW-1:0] word_q, word_nx;
  logic [LW-1:0] lane_q;

  assign lane_last = (lane_q == LW'(BYTES - 1));

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign word_nx[g*BW +: BW] = load_word ? word_in[g*BW +: BW] :
                                 (put_byte && lane_q == LW'(g)) ? byte_in :
                                 word_q[g*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      lane_q <= '0;
    end else begin
      word_q <= word_nx;
      if (clr_lane || load_word) lane_q <= '0;
      else if (put_byte || adv) lane_q <= lane_last ? '0 : lane_q + 1'b1;
    end
  end

  assign word_out = word_q;
  assign byte_out = word_q[lane_q*BW +: BW];
endmodule

// File: rtl/wdma_ptr_cnt.sv
module wdma_ptr_cnt #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_addr,
  input  logic [AW-1:0] addr_din,
  input  logic          ld_cnt,
  input  logic [CW-1:0] cnt_din,
  input  logic          step_addr,
  input  logic          step_cnt,
  output logic [AW-1:0] addr_q,
  output logic          cnt_one,
  output logic          cnt_zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ld_addr) addr_q <= addr_din;
      else if (step_addr) addr_q <= addr_q + 1'b1;
      if (ld_cnt) cnt_q <= cnt_din;
      else if (step_cnt && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_one  = (cnt_q == CW'(1));
  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/wdma_ctrl.sv
module wdma_ctrl #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int BW    = 8,
  parameter int BYTES = 4,
  localparam int DW   = BW * BYTES,
  localparam int RW   = (AW > CW) ? AW : CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [RW-1:0] cfg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  input  logic          in_valid,
  input  logic [BW-1:0] in_data,
  input  logic          in_err,
  output logic          in_ready,
  output logic          out_valid,
  output logic [BW-1:0] out_data,
  input  logic          out_ready,
  output logic          irq_done,
  output logic          irq_err,
  output logic          busy
);
  import wdma_pkg::*;

  wdma_state_e state_q, state_nx;
  logic irq_done_q, irq_err_q;
  logic idle, start, clr, accept, bad, put_byte;
  logic store_gnt, fetch_gnt, emit, word_sent, done_set;
  logic lane_last, cnt_one, cnt_zero;
  logic ctl_wr;

  assign idle      = (state_q == ST_IDLE);
  assign ctl_wr    = cfg_we && cfg_sel == SEL_CTRL;
  assign start     = ctl_wr && cfg_wdata[CTL_START] && idle;
  assign clr       = ctl_wr && cfg_wdata[CTL_CLR];
  assign accept    = (state_q == ST_FILL) && in_valid;
  assign bad       = accept && in_err;
  assign put_byte  = accept && !in_err;
  assign store_gnt = (state_q == ST_STORE) && mem_gnt;
  assign fetch_gnt = (state_q == ST_FETCH) && mem_gnt;
  assign emit      = (state_q == ST_DRAIN) && out_ready;
  assign word_sent = emit && lane_last;
  assign done_set  = (start && cnt_zero) || ((store_gnt || word_sent) && cnt_one);

  wdma_ptr_cnt #(.AW(AW), .CW(CW)) i_ptr (
    .clk       (clk),
    .rst       (rst),
    .ld_addr   (cfg_we && cfg_sel == SEL_ADDR && idle),
    .addr_din  (cfg_wdata[AW-1:0]),
    .ld_cnt    (cfg_we && cfg_sel == SEL_COUNT && idle),
    .cnt_din   (cfg_wdata[CW-1:0]),
    .step_addr (store_gnt || fetch_gnt),
    .step_cnt  (store_gnt || word_sent),
    .addr_q    (mem_addr),
    .cnt_one   (cnt_one),
    .cnt_zero  (cnt_zero)
  );

  wdma_word_buf #(.BW(BW), .BYTES(BYTES)) i_buf (
    .clk       (clk),
    .rst       (rst),
    .clr_lane  (start),
    .load_word (fetch_gnt),
    .word_in   (mem_rdata),
    .put_byte  (put_byte),
    .byte_in   (in_data),
    .adv       (emit),
    .lane_last (lane_last),
    .word_out  (mem_wdata),
    .byte_out  (out_data)
  );

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE:  if (start && !cnt_zero)
                  state_nx = cfg_wdata[CTL_DIR] ? ST_FETCH : ST_FILL;
      ST_FILL:  if (bad) state_nx = ST_IDLE;
                else if (accept && lane_last) state_nx = ST_STORE;
      ST_STORE: if (mem_gnt) state_nx = cnt_one ? ST_IDLE : ST_FILL;
      ST_FETCH: if (mem_gnt) state_nx = ST_DRAIN;
      ST_DRAIN: if (word_sent) state_nx = cnt_one ? ST_IDLE : ST_FETCH;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      irq_done_q <= 1'b0;
      irq_err_q  <= 1'b0;
    end else begin
      state_q    <= state_nx;
      irq_done_q <= (irq_done_q && !clr) || done_set;
      irq_err_q  <= (irq_err_q && !clr) || bad;
    end
  end

  assign mem_req   = (state_q == ST_STORE) || (state_q == ST_FETCH);
  assign mem_we    = (state_q == ST_STORE);
  assign in_ready  = (state_q == ST_FILL);
  assign out_valid = (state_q == ST_DRAIN);
  assign busy      = !idle;
  assign irq_done  = irq_done_q;
  assign irq_err   = irq_err_q;
endmodule

// File: rtl/wdma_ctrl_chk.sv
module wdma_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_gnt,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_err,
  input logic          out_valid,
  input logic          irq_done,
  input logic          irq_err,
  input logic          busy
);
  // R5: request and its payload hold until granted
  a_r5_hold_until_gnt: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R6: a granted access moves the address on by one word
  a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_gnt |=> mem_addr == AW'($past(mem_addr) + 1'b1));

  // R4: no character intake while a write is outstanding
  a_r4_no_fill_while_req: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && mem_req));

  // R9: a flagged character halts and raises the error interrupt
  a_r9_err_halts: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_err |=> irq_err && !busy);

  // R7: completion is only signalled once the engine is idle
  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_done) |-> !busy);

  // R1: an idle engine drives no handshake
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req && !in_ready && !out_valid);

  // R10: the two stream directions never run together
  a_r10_one_direction: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));
endmodule

bind wdma_ctrl wdma_ctrl_chk #(.AW(AW), .DW(DW)) i_chk (.*);

// File: tb/test_wdma_ctrl.sv
`timescale 1ns/1ps
module test_wdma_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        mem_req, mem_we, mem_gnt = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        in_valid = 1'b0, in_err = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_ready;
  logic [7:0]  out_data;
  logic        irq_done, irq_err, busy;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [16];
  int mem_lat = 0, wait_cnt = 0, n_wr = 0, n_rd = 0;
  logic [15:0] last_rd_addr = '0, first_addr = '0;
  logic seen_req = 1'b0, holding = 1'b0;
  logic [15:0] held_addr; logic [31:0] held_wdata; logic held_we;
  logic slow_sink = 1'b0, sink_phase = 1'b0;
  logic [7:0] got [16];
  int n_got = 0;

  always #2.5 clk = ~clk;

  wdma_ctrl i_wdma_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_err(in_err), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .irq_done(irq_done), .irq_err(irq_err), .busy(busy));

  assign mem_rdata = mem[mem_addr[3:0]];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: grant after mem_lat waiting cycles, checks R5 hold
  always @(negedge clk) begin
    if (mem_gnt) begin
      mem_gnt = 1'b0;
      holding = 1'b0;
    end else if (mem_req) begin
      if (!seen_req) begin first_addr = mem_addr; seen_req = 1'b1; end
      if (holding)
        chk(mem_addr == held_addr && mem_we == held_we && mem_wdata == held_wdata,
            "R5 hold", mem_addr, held_addr);
      holding = 1'b1; held_addr = mem_addr; held_we = mem_we; held_wdata = mem_wdata;
      if (wait_cnt >= mem_lat) begin
        mem_gnt = 1'b1; wait_cnt = 0;
        if (mem_we) begin mem[mem_addr[3:0]] = mem_wdata; n_wr++; end
        else begin n_rd++; last_rd_addr = mem_addr; end
      end else wait_cnt++;
    end
  end

  // character sink with optional back-pressure
  always @(negedge clk) begin
    sink_phase = ~sink_phase;
    out_ready = slow_sink ? sink_phase : 1'b1;
    if (out_valid && out_ready && n_got < 16) begin got[n_got] = out_data; n_got++; end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic e);
    @(negedge clk); in_valid = 1'b1; in_data = b; in_err = e;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 1'b0; in_err = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    while (busy && k < 2000) begin @(negedge clk); k++; end
    chk(!busy, tag, busy, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !mem_req && !in_ready && !out_valid, "R1 idle handshake", {busy, mem_req, in_ready, out_valid}, 0);
    chk(!irq_done && !irq_err, "R1 interrupts", {irq_done, irq_err}, 0);
  endtask

  task automatic t_zero_count;
    int w = n_wr, r = n_rd;
    cfg_write(2'd0, 16'd3);
    cfg_write(2'd1, 16'd0);
    cfg_write(2'd2, 16'h0001);
    chk(irq_done == 1'b1, "R8 done after zero start", irq_done, 1);
    chk(!busy, "R8 stays idle", busy, 0);
    repeat (3) @(negedge clk);
    chk(n_wr == w && n_rd == r, "R8 no memory access", n_wr + n_rd, w + r);
    cfg_write(2'd2, 16'h0004);
    chk(!irq_done, "R11 clear done", irq_done, 0);
  endtask

  task automatic t_input_pack;
    int w = n_wr;
    mem_lat = 2; seen_req = 1'b0;
    cfg_write(2'd0, 16'd8);
    cfg_write(2'd1, 16'd2);
    cfg_write(2'd2, 16'h0001);
    chk(busy && in_ready, "R2 start input direction", {busy, in_ready}, 2'b11);
    send_byte(8'h11, 0); send_byte(8'h22, 0); send_byte(8'h33, 0);
    repeat (3) @(negedge clk);
    chk(!mem_req && n_wr == w, "R4 no write before full word", mem_req, 0);
    send_byte(8'h44, 0);
    chk(mem_req && mem_we && !in_ready, "R4 write pending blocks input", {mem_req, mem_we, in_ready}, 3'b110);
    chk(mem_addr == 16'd8, "R6 first address", mem_addr, 8);
    send_byte(8'h55, 0); send_byte(8'h66, 0); send_byte(8'h77, 0); send_byte(8'h88, 0);
    wait_idle("R7 input ends");
    chk(mem[8] == 32'h44332211, "R3 word 0 little-endian", mem[8], 32'h44332211);
    chk(mem[9] == 32'h88776655, "R3 word 1 little-endian", mem[9], 32'h88776655);
    chk(n_wr == w + 2, "R7 word count", n_wr - w, 2);
    chk(irq_done, "R7 done raised", irq_done, 1);
    cfg_write(2'd2, 16'h0004);
  endtask

  task automatic t_error;
    int w = n_wr;
    mem_lat = 0; mem[12] = 32'hDEADBEEF;
    cfg_write(2'd0, 16'd12);
    cfg_write(2'd1, 16'd2);
    cfg_write(2'd2, 16'h0001);
    send_byte(8'hA0, 0); send_byte(8'hA1, 0); send_byte(8'hA2, 1);
    chk(irq_err && !busy && !in_ready, "R9 error halts", {irq_err, busy, in_ready}, 3'b100);
    repeat (6) @(negedge clk);
    chk(n_wr == w && mem[12] == 32'hDEADBEEF, "R9 no write after error", mem[12], 32'hDEADBEEF);
    chk(!irq_done, "R9 no completion", irq_done, 0);
    cfg_write(2'd2, 16'h0004);
    chk(!irq_err, "R11 clear error", irq_err, 0);
  endtask

  task automatic t_output(input logic [15:0] base, input bit disturb);
    int r = n_rd;
    logic [31:0] w0 = 32'hA1B2C3D4 ^ {16'h0, base};
    logic [31:0] w1 = 32'h01020304 + {16'h0, base};
    logic [31:0] wv;
    mem[base[3:0]] = w0; mem[base[3:0] + 4'd1] = w1;
    mem_lat = 1; slow_sink = 1'b1; n_got = 0;
    cfg_write(2'd0, base);
    cfg_write(2'd1, 16'd2);
    cfg_write(2'd2, 16'h0003);
    if (disturb) begin
      cfg_write(2'd0, 16'd0);
      cfg_write(2'd1, 16'd9);
      cfg_write(2'd2, 16'h0001);
    end
    wait_idle(disturb ? "R12 output ends" : "R7 output ends");
    chk(n_got == 8, disturb ? "R12 byte count" : "R10 byte count", n_got, 8);
    for (int i = 0; i < 8; i++) begin
      wv = (i < 4) ? w0 : w1;
      chk(got[i] == wv[(i%4)*8 +: 8], disturb ? "R12 byte order" : "R10 byte order", got[i], wv[(i%4)*8 +: 8]);
    end
    chk(n_rd == r + 2 && last_rd_addr == base + 16'd1, disturb ? "R12 reads" : "R6 reads", last_rd_addr, base + 16'd1);
    chk(irq_done, "R7 done after output", irq_done, 1);
    slow_sink = 1'b0;
    cfg_write(2'd2, 16'h0004);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero_count();
    t_input_pack();
    t_error();
    t_output(16'd4, 1'b0);
    t_output(16'd6, 1'b1);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    finish_run();
  end
endmodule